// File: doc/BRIEF.md
# Two-Register ALU Execute Stage

This block is the execute stage for the register-to-register arithmetic and logic class of a compact 16-bit instruction encoding. A decoder hands it a 4-bit operation code, the current contents of the destination register, the contents of the source register and the current condition flags (N, Z, C, V). One clock edge later it presents a 32-bit result, a register write strobe and the next flags.

The sixteen operations cover bitwise logic, add and subtract with carry, negate, compare-style tests, shifts whose amount comes from a register, a truncating multiply, and bit clear. Each operation has its own rule for which flags it changes and whether the destination is written back. Instruction fetch, other instruction formats, the register file and multiply timing belong to neighbouring blocks.

Top module: `cisa_reg_alu`

## Requirements
- R1: The op code selects the operation as 0 AND, 1 EOR, 2 LSL, 3 LSR, 4 ASR, 5 ADC, 6 SBC, 7 ROR, 8 TST, 9 NEG, 10 CMP, 11 CMN, 12 ORR, 13 MUL, 14 BIC, 15 MVN. AND, EOR and ORR combine dst and src bitwise, BIC gives dst & ~src, MVN gives ~src and TST computes dst & src.
- R2: TST, CMP and CMN drive wr_en_o low. All other ops drive it high with valid_o. result_o still carries the computed value.
- R3: ADC gives dst + src + C. SBC gives dst - src - (1 - C). CMP and CMN give dst - src and dst + src. For subtract-style ops C is set when no borrow occurs. V is set on signed overflow.
- R4: NEG gives 0 - src, with subtract-style C and V.
- R5: LSL, LSR, ASR and ROR shift dst by src[7:0] and set C to the last bit shifted out. An amount of 32 gives 0 with C = dst[0] (LSL) or dst[31] (LSR). An amount above 32 gives 0 with C = 0 for LSL and LSR. An amount of 32 or more for ASR fills with dst[31] and C = dst[31]. For ROR the rotation is the amount mod 32, and a non-zero multiple of 32 leaves the value with C = dst[31]. Shifts leave V unchanged.
- R6: A shift amount of zero in src[7:0], whatever the upper bits, leaves the value and C unchanged.
- R7: MUL returns the low 32 bits of dst * src and forces C and V to 0.
- R8: AND, EOR, ORR, BIC, MVN and TST leave C and V unchanged.
- R9: For every op, N equals result bit 31 and Z is set when the 32-bit result is zero. flags_i and flags_o are packed {N, Z, C, V} with N at bit 3.
- R10: valid_o rises on the clock edge after a cycle with valid_i high. wr_en_o is never high without valid_o. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Operation code |
| dst_i | input | 32 | Destination register operand |
| src_i | input | 32 | Source register operand |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| valid_o | output | 1 | Result valid |
| result_o | output | 32 | Computed result |
| wr_en_o | output | 1 | Write result to destination |
| flags_o | output | 4 | Next flags {N,Z,C,V} |

## Verification
The bench targets the shift-amount boundaries at 0, 1, 32, above 32 and a zero low byte with non-zero upper bits. A design that masked only five bits, or treated 32 like 0, would return the unshifted value or the wrong carry. It drives carry-in on ADC and SBC in both polarities and uses NEG of zero and of the most negative value. An inverted borrow sense or an overflow computed on the uninverted operand would show up as a wrong C or V. It also checks that compare-style ops keep the write strobe low and that logical ops and MUL leave or clear C and V as required. A decoder that wrote back on a test, or let stale carry through a multiply, would fail those checks.

// File: rtl/ralu_pkg.sv
package ralu_pkg;
  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_LSL = 4'h2, OP_LSR = 4'h3,
    OP_ASR = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_ROR = 4'h7,
    OP_TST = 4'h8, OP_NEG = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MUL = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } alu_op_e;

  typedef enum logic [1:0] {SH_LSL, SH_LSR, SH_ASR, SH_ROR} shift_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;
endpackage

// File: rtl/ralu_shifter.sv
module ralu_shifter
  import ralu_pkg::*;
#(
  parameter int W = 32,
  parameter int AMT_W = 8
) (
  input  shift_kind_e      kind_i,
  input  logic [W-1:0]     val_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             c_i,
  output logic [W-1:0]     val_o,
  output logic             c_o
);
  localparam int SW = $clog2(W);

  logic [W:0]    wide;
  logic [SW-1:0] low;
  logic          amt_zero, amt_eq_w, amt_gt_w;

  assign low      = amt_i[SW-1:0];
  assign amt_zero = (amt_i == '0);
  assign amt_eq_w = (amt_i == AMT_W'(W));
  assign amt_gt_w = (amt_i > AMT_W'(W));

  always_comb begin
    wide  = '0;
    val_o = val_i;
    c_o   = c_i;
    if (!amt_zero) begin
      unique case (kind_i)
        SH_LSL: begin
          if (amt_gt_w) begin
            val_o = '0; c_o = 1'b0;
          end else if (amt_eq_w) begin
            val_o = '0; c_o = val_i[0];
          end else begin
            wide  = {1'b0, val_i} << low;
            val_o = wide[W-1:0];
            c_o   = wide[W];
          end
        end
        SH_LSR: begin
          if (amt_gt_w) begin
            val_o = '0; c_o = 1'b0;
          end else if (amt_eq_w) begin
            val_o = '0; c_o = val_i[W-1];
          end else begin
            wide  = {val_i, 1'b0} >> low;
            val_o = wide[W:1];
            c_o   = wide[0];
          end
        end
        SH_ASR: begin
          if (amt_gt_w || amt_eq_w) begin
            val_o = {W{val_i[W-1]}};
            c_o   = val_i[W-1];
          end else begin
            wide  = $unsigned($signed({val_i, 1'b0}) >>> low);
            val_o = wide[W:1];
            c_o   = wide[0];
          end
        end
        default: begin
          // rotate; carry is the bit that lands in the top position
          val_o = (val_i >> low) | (val_i << (W - {1'b0, low}));
          c_o   = val_o[W-1];
        end
      endcase
    end
  end
endmodule

// File: rtl/ralu_adder.sv
module ralu_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         inv_b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         c_o,
  output logic         v_o
);
  logic [W-1:0] bx;
  logic [W:0]   full;

  assign bx    = inv_b_i ? ~b_i : b_i;
  assign full  = {1'b0, a_i} + {1'b0, bx} + {{W{1'b0}}, cin_i};
  assign sum_o = full[W-1:0];
  assign c_o   = full[W];
  assign v_o   = (a_i[W-1] == bx[W-1]) && (sum_o[W-1] != a_i[W-1]);
endmodule

// File: rtl/ralu_decode.sv
module ralu_decode
  import ralu_pkg::*;
(
  input  alu_op_e     op_i,
  input  logic        c_i,
  output logic        use_dst_o,
  output logic        inv_b_o,
  output logic        cin_o,
  output logic        is_arith_o,
  output logic        is_shift_o,
  output logic        is_mul_o,
  output logic        writes_o,
  output shift_kind_e kind_o
);
  always_comb begin
    use_dst_o  = 1'b1;
    inv_b_o    = 1'b0;
    cin_o      = 1'b0;
    is_arith_o = 1'b0;
    is_shift_o = 1'b0;
    is_mul_o   = 1'b0;
    writes_o   = 1'b1;
    kind_o     = SH_LSL;
    unique case (op_i)
      OP_ADC: begin is_arith_o = 1'b1; cin_o = c_i; end
      OP_SBC: begin is_arith_o = 1'b1; inv_b_o = 1'b1; cin_o = c_i; end
      OP_NEG: begin is_arith_o = 1'b1; inv_b_o = 1'b1; cin_o = 1'b1; use_dst_o = 1'b0; end
      OP_CMP: begin is_arith_o = 1'b1; inv_b_o = 1'b1; cin_o = 1'b1; writes_o = 1'b0; end
      OP_CMN: begin is_arith_o = 1'b1; writes_o = 1'b0; end
      OP_TST: writes_o = 1'b0;
      OP_LSL: begin is_shift_o = 1'b1; kind_o = SH_LSL; end
      OP_LSR: begin is_shift_o = 1'b1; kind_o = SH_LSR; end
      OP_ASR: begin is_shift_o = 1'b1; kind_o = SH_ASR; end
      OP_ROR: begin is_shift_o = 1'b1; kind_o = SH_ROR; end
      OP_MUL: is_mul_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/cisa_reg_alu.sv
module cisa_reg_alu
  import ralu_pkg::*;
#(
  parameter int W = 32,
  parameter int AMT_W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] dst_i,
  input  logic [W-1:0] src_i,
  input  logic [3:0]   flags_i,
  output logic         valid_o,
  output logic [W-1:0] result_o,
  output logic         wr_en_o,
  output logic [3:0]   flags_o
);
  alu_op_e     op;
  alu_flags_t  fin, fnext, flags_q;
  shift_kind_e kind;
  logic        use_dst, inv_b, cin, is_arith, is_shift, is_mul, writes;
  logic [W-1:0] add_a, sum, sh_val, res;
  logic        add_c, add_v, sh_c;

  assign op  = alu_op_e'(op_i);
  assign fin = alu_flags_t'(flags_i);

  ralu_decode u_dec (
    .op_i(op), .c_i(fin.c), .use_dst_o(use_dst), .inv_b_o(inv_b), .cin_o(cin),
    .is_arith_o(is_arith), .is_shift_o(is_shift), .is_mul_o(is_mul),
    .writes_o(writes), .kind_o(kind)
  );

  assign add_a = use_dst ? dst_i : '0;

  ralu_adder #(.W(W)) u_add (
    .a_i(add_a), .b_i(src_i), .inv_b_i(inv_b), .cin_i(cin),
    .sum_o(sum), .c_o(add_c), .v_o(add_v)
  );

  ralu_shifter #(.W(W), .AMT_W(AMT_W)) u_shf (
    .kind_i(kind), .val_i(dst_i), .amt_i(src_i[AMT_W-1:0]), .c_i(fin.c),
    .val_o(sh_val), .c_o(sh_c)
  );

  always_comb begin
    unique case (op)
      OP_AND, OP_TST: res = dst_i & src_i;
      OP_EOR:         res = dst_i ^ src_i;
      OP_ORR:         res = dst_i | src_i;
      OP_BIC:         res = dst_i & ~src_i;
      OP_MVN:         res = ~src_i;
      OP_MUL:         res = dst_i * src_i;
      default:        res = is_shift ? sh_val : sum;
    endcase
  end

  always_comb begin
    fnext   = fin;
    fnext.n = res[W-1];
    fnext.z = (res == '0);
    if (is_arith) begin
      fnext.c = add_c;
      fnext.v = add_v;
    end else if (is_shift) begin
      fnext.c = sh_c;
    end else if (is_mul) begin
      fnext.c = 1'b0;
      fnext.v = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      wr_en_o  <= 1'b0;
      result_o <= '0;
      flags_q  <= '0;
    end else begin
      valid_o <= valid_i;
      wr_en_o <= valid_i & writes;
      if (valid_i) begin
        result_o <= res;
        flags_q  <= fnext;
      end
    end
  end

  assign flags_o = flags_q;

  p_test_no_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == 4'h8 || op_i == 4'hA || op_i == 4'hB) |=> !wr_en_o);

  p_mul_clears_cv_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == 4'hD |=> flags_o[1:0] == 2'b00);

  p_logic_keeps_cv_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i == 4'h0 || op_i == 4'h1 || op_i == 4'h8 || op_i >= 4'hE || op_i == 4'hC)
    |=> flags_o[1:0] == $past(flags_i[1:0]));

  p_shift_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (op_i inside {4'h2, 4'h3, 4'h4, 4'h7}) && src_i[AMT_W-1:0] == '0
    |=> result_o == $past(dst_i) && flags_o[1] == $past(flags_i[1]));

  p_nz_match_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> flags_o[3] == result_o[W-1] && flags_o[2] == (result_o == '0));

  p_valid_follow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_wr_needs_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> valid_o);
endmodule

// File: tb/cisa_reg_alu_tb.sv
module cisa_reg_alu_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] dst_i = '0, src_i = '0;
  logic [3:0]  flags_i = '0;
  logic        valid_o, wr_en_o;
  logic [31:0] result_o;
  logic [3:0]  flags_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cisa_reg_alu dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i),
    .dst_i(dst_i), .src_i(src_i), .flags_i(flags_i),
    .valid_o(valid_o), .result_o(result_o), .wr_en_o(wr_en_o), .flags_o(flags_o)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic run_op(string req, logic [3:0] op, logic [31:0] d, logic [31:0] s,
                        logic [3:0] fl, logic [31:0] exp_res, logic exp_we,
                        logic [3:0] exp_fl);
    @(negedge clk);
    valid_i = 1'b1; op_i = op; dst_i = d; src_i = s; flags_i = fl;
    @(negedge clk);
    valid_i = 1'b0;
    check(req, "valid", {31'b0, valid_o}, 32'd1);
    check(req, "result", result_o, exp_res);
    check(req, "wr_en", {31'b0, wr_en_o}, {31'b0, exp_we});
    check(req, "flags", {28'b0, flags_o}, {28'b0, exp_fl});
  endtask

  task automatic t_reset();
    check("R10", "reset valid", {31'b0, valid_o}, 32'd0);
    check("R10", "reset wr_en", {31'b0, wr_en_o}, 32'd0);
    check("R10", "reset result", result_o, 32'd0);
    check("R10", "reset flags", {28'b0, flags_o}, 32'd0);
  endtask

  task automatic t_logic();
    run_op("R1", 4'h0, 32'hF0F0_00FF, 32'h0FF0_0F0F, 4'b0011, 32'h00F0_000F, 1'b1, 4'b0011);
    run_op("R1", 4'h1, 32'hFFFF_0000, 32'h0000_FFFF, 4'b0000, 32'hFFFF_FFFF, 1'b1, 4'b1000);
    run_op("R8", 4'hC, 32'h0, 32'h0, 4'b1010, 32'h0, 1'b1, 4'b0110);
    run_op("R1", 4'hE, 32'hFFFF_FFFF, 32'h0000_00FF, 4'b0001, 32'hFFFF_FF00, 1'b1, 4'b1001);
    run_op("R9", 4'hF, 32'h0, 32'h8000_0000, 4'b1100, 32'h7FFF_FFFF, 1'b1, 4'b0000);
  endtask

  task automatic t_compare();
    run_op("R2", 4'h8, 32'h1, 32'h2, 4'b0011, 32'h0, 1'b0, 4'b0111);
    run_op("R2", 4'hA, 32'h8000_0000, 32'h1, 4'b0000, 32'h7FFF_FFFF, 1'b0, 4'b0011);
    run_op("R2", 4'hB, 32'h1, 32'hFFFF_FFFF, 4'b1001, 32'h0, 1'b0, 4'b0110);
  endtask

  task automatic t_carry_arith();
    run_op("R3", 4'h5, 32'hFFFF_FFFF, 32'h0, 4'b0010, 32'h0, 1'b1, 4'b0110);
    run_op("R3", 4'h5, 32'h7FFF_FFFF, 32'h0, 4'b0010, 32'h8000_0000, 1'b1, 4'b1001);
    run_op("R3", 4'h6, 32'd5, 32'd3, 4'b0000, 32'd1, 1'b1, 4'b0010);
    run_op("R3", 4'h6, 32'd3, 32'd5, 4'b0010, 32'hFFFF_FFFE, 1'b1, 4'b1000);
  endtask

  task automatic t_negate();
    run_op("R4", 4'h9, 32'h1234, 32'h1, 4'b0000, 32'hFFFF_FFFF, 1'b1, 4'b1000);
    run_op("R4", 4'h9, 32'h1234, 32'h0, 4'b0000, 32'h0, 1'b1, 4'b0110);
    run_op("R4", 4'h9, 32'h0, 32'h8000_0000, 4'b0000, 32'h8000_0000, 1'b1, 4'b1001);
  endtask

  task automatic t_shifts();
    run_op("R5", 4'h2, 32'h1234_5678, 32'd4, 4'b0001, 32'h2345_6780, 1'b1, 4'b0011);
    run_op("R5", 4'h2, 32'h0000_0001, 32'd32, 4'b0000, 32'h0, 1'b1, 4'b0110);
    run_op("R5", 4'h2, 32'hFFFF_FFFF, 32'd33, 4'b0010, 32'h0, 1'b1, 4'b0100);
    run_op("R5", 4'h3, 32'h0000_0003, 32'd1, 4'b0000, 32'h1, 1'b1, 4'b0010);
    run_op("R5", 4'h3, 32'h8000_0000, 32'd32, 4'b0000, 32'h0, 1'b1, 4'b0110);
    run_op("R5", 4'h4, 32'h8000_0010, 32'd4, 4'b0010, 32'hF800_0001, 1'b1, 4'b1000);
    run_op("R5", 4'h4, 32'h8000_0000, 32'd40, 4'b0000, 32'hFFFF_FFFF, 1'b1, 4'b1010);
    run_op("R5", 4'h7, 32'h0000_00A5, 32'd8, 4'b0000, 32'hA500_0000, 1'b1, 4'b1010);
    run_op("R5", 4'h7, 32'h8000_0001, 32'd32, 4'b0001, 32'h8000_0001, 1'b1, 4'b1011);
  endtask

  task automatic t_shift_zero();
    run_op("R6", 4'h2, 32'h8000_0000, 32'h0000_0100, 4'b0010, 32'h8000_0000, 1'b1, 4'b1010);
    run_op("R6", 4'h7, 32'h0000_0001, 32'h0, 4'b0000, 32'h1, 1'b1, 4'b0000);
    run_op("R6", 4'h3, 32'h0000_0000, 32'hFFFF_FF00, 4'b0011, 32'h0, 1'b1, 4'b0111);
  endtask

  task automatic t_multiply();
    run_op("R7", 4'hD, 32'h0001_0001, 32'h0001_0001, 4'b0011, 32'h0002_0001, 1'b1, 4'b0000);
    run_op("R7", 4'hD, 32'h8000_0000, 32'd2, 4'b1111, 32'h0, 1'b1, 4'b0100);
  endtask

  task automatic t_idle();
    @(negedge clk);
    check("R10", "idle valid", {31'b0, valid_o}, 32'd0);
    check("R10", "idle wr_en", {31'b0, wr_en_o}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_logic();
    t_compare();
    t_carry_arith();
    t_negate();
    t_shifts();
    t_shift_zero();
    t_multiply();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule